// File: doc/BRIEF.md
# FM0 Baseband Line Encoder with Preamble

This block turns a serial payload into the bi-phase space (FM0) baseband waveform that a tag sends back to a reader. Every symbol is built as a pair of half-symbol levels. The pair is shown on a two-bit output and then shifted onto a single line output, one half per half-bit tick. The tick period is therefore the only thing that sets the bit rate. For example, a 40 to 640 kbit/s link needs ticks at twice that rate.

A frame has four parts, in this order:
- An optional pilot of twelve data-0 symbols, selected by the pilot-enable input at start.
- A six-symbol preamble that carries one deliberate coding violation.
- The payload. Its bits are fetched one per symbol through a request pulse.
- A single dummy data-1 symbol.

After the dummy symbol the line returns to idle low, and a one-clock done pulse is given.

The controller is a state machine with these states: `ST_IDLE`, `ST_PILOT`, `ST_PREAMB`, `ST_PAYLOAD`, `ST_TAIL` and `ST_FINISH`. It moves between them as follows:
- Idle to pilot, on an accepted start with the pilot enabled.
- Idle to preamble, on an accepted start with the pilot disabled.
- Pilot to preamble, after the twelfth pilot symbol.
- Preamble to payload, after the sixth preamble symbol.
- Payload to tail, after the last payload bit.
- Tail to finish, after the dummy symbol.
- Finish to idle, on the next tick. This is where done pulses.

Top module: `fm0_line_encoder`

## Requirements
- R1: After reset, `line_o` is 0, `half_pair_o` is 2'b00, `done_o` is 0 and `bit_req_o` is 0.
- R2: Each symbol starts with the inverse of the previous half level. A data 0 inverts again at mid-symbol; a data 1 holds. `half_pair_o[1]` is the first half and `half_pair_o[0]` is the second half.
- R3: `line_o` changes only in the clock after a cycle with `tick_i` high. The first tick of a symbol puts its first half on the line and the next tick puts its second half. No half appears before the first tick that follows the start cycle.
- R4: The preamble is the symbol sequence 1,0,1,0,V,1. V repeats the previous level for both of its halves, so it has no boundary inversion and no mid inversion.
- R5: When `pilot_en_i` is 1 at start, twelve data-0 symbols come before the preamble.
- R6: `nbits_i` (1 to 127) is captured at start. `bit_req_o` is high for one clock, and only in a tick cycle, once before every payload symbol. `bit_i` is sampled in that same cycle. Exactly `nbits_i` requests are made, and the bits are sent in request order.
- R7: One dummy data-1 symbol follows the last payload bit. On the next tick the line returns to 0 and `half_pair_o` returns to 2'b00.
- R8: `done_o` is high for exactly one clock, in the same clock in which the line returns low after the dummy symbol.
- R9: `start_i` is ignored while a frame is in progress, and it is ignored when `nbits_i` is 0. A tick in the start cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (accepted only in idle) |
| pilot_en_i | input | 1 | Prepend the twelve-symbol pilot |
| nbits_i | input | CNT_W | Payload length in bits |
| tick_i | input | 1 | Half-bit pacing strobe |
| bit_i | input | 1 | Payload bit; must be valid while `bit_req_o` is high |
| bit_req_o | output | 1 | Request for the next payload bit |
| half_pair_o | output | 2 | Current symbol's {first half, second half} |
| line_o | output | 1 | Serialized FM0 line |
| done_o | output | 1 | One-clock end-of-frame pulse |

## Verification
All results are registered on a tick edge, so each one is due one clock after the tick cycle that causes it:
- A line half and its pair appear one clock after their tick.
- The return to low, together with `done_o`, appears one clock after the tick that follows the dummy symbol.
- `bit_req_o` is combinational and shows during the tick cycle that ends the symbol before a payload symbol.

The bench drives ticks only on falling edges. It records whether the preceding rising edge carried a tick. Its monitor compares one queued expected half-symbol on the falling edge after each such tick, which is exactly where the registered output has settled. Requests are counted on rising edges, and the payload bit is switched with a nonblocking update so that the design samples the bit that was requested.

// File: rtl/fm0_enc_pkg.sv
`timescale 1ns/1ps
package fm0_enc_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_VIOL = 2'd2
    } sym_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PILOT   = 3'd1,
        ST_PREAMB  = 3'd2,
        ST_PAYLOAD = 3'd3,
        ST_TAIL    = 3'd4,
        ST_FINISH  = 3'd5
    } enc_state_e;

    localparam int PREAMB_SYMS = 6;

endpackage

// File: rtl/fm0_pattern_src.sv
`timescale 1ns/1ps
module fm0_pattern_src
    import fm0_enc_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  enc_state_e       st_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             data_bit_i,
    output sym_kind_e        kind_o
);

    // Picks which symbol kind the current stage position calls for.
    always_comb begin
        kind_o = SYM_ONE;
        unique case (st_i)
            ST_PILOT:   kind_o = SYM_ZERO;
            ST_PREAMB: begin
                if (idx_i == IDX_W'(1) || idx_i == IDX_W'(3)) begin
                    kind_o = SYM_ZERO;
                end else if (idx_i == IDX_W'(4)) begin
                    kind_o = SYM_VIOL;
                end else begin
                    kind_o = SYM_ONE;
                end
            end
            ST_PAYLOAD: kind_o = data_bit_i ? SYM_ONE : SYM_ZERO;
            ST_TAIL:    kind_o = SYM_ONE;
            default:    kind_o = SYM_ONE;
        endcase
    end

endmodule

// File: rtl/fm0_sym_coder.sv
`timescale 1ns/1ps
module fm0_sym_coder
    import fm0_enc_pkg::*;
(
    input  sym_kind_e  kind_i,
    input  logic       prev_lvl_i,
    output logic [1:0] pair_o
);

    logic first_half;
    logic second_half;

    // Boundary inversion unless violation; mid inversion only for data 0.
    always_comb begin
        first_half  = (kind_i == SYM_VIOL) ? prev_lvl_i : ~prev_lvl_i;
        second_half = (kind_i == SYM_ZERO) ? ~first_half : first_half;
        pair_o      = {first_half, second_half};
    end

endmodule

// File: rtl/fm0_half_shifter.sv
`timescale 1ns/1ps
module fm0_half_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] pair_i,
    input  logic       shift_i,
    input  logic       clear_i,
    output logic [1:0] pair_o,
    output logic       line_o,
    output logic       second_pending_o
);

    logic [1:0] pair_q;
    logic       line_q;
    logic       second_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q   <= 2'b00;
            line_q   <= 1'b0;
            second_q <= 1'b0;
        end else if (clear_i) begin
            pair_q   <= 2'b00;
            line_q   <= 1'b0;
            second_q <= 1'b0;
        end else if (load_i) begin
            pair_q   <= pair_i;
            line_q   <= pair_i[1];
            second_q <= 1'b1;
        end else if (shift_i) begin
            line_q   <= pair_q[0];
            second_q <= 1'b0;
        end
    end

    assign pair_o           = pair_q;
    assign line_o           = line_q;
    assign second_pending_o = second_q;

endmodule

// File: rtl/fm0_line_encoder.sv
`timescale 1ns/1ps
module fm0_line_encoder
    import fm0_enc_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int PILOT_SYMS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pilot_en_i,
    input  logic [CNT_W-1:0] nbits_i,
    input  logic             tick_i,
    input  logic             bit_i,
    output logic             bit_req_o,
    output logic [1:0]       half_pair_o,
    output logic             line_o,
    output logic             done_o
);

    localparam int PIL_W  = $clog2(PILOT_SYMS + 1);
    localparam int BASE_W = (CNT_W > PIL_W) ? CNT_W : PIL_W;
    localparam int IDX_W  = (BASE_W > 3) ? BASE_W : 3;

    enc_state_e       state_q, state_d, follow_st;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] nbits_q, nbits_d;
    logic             bit_q;
    logic             done_q;

    logic             active, stage_end, second_pending;
    logic             do_load, do_shift, do_clear, want_bit;
    sym_kind_e        cur_kind;
    logic [1:0]       cur_pair;

    // Stage bookkeeping
    always_comb begin
        active = (state_q == ST_PILOT) || (state_q == ST_PREAMB) ||
                 (state_q == ST_PAYLOAD) || (state_q == ST_TAIL);
        unique case (state_q)
            ST_PILOT:   stage_end = (idx_q == IDX_W'(PILOT_SYMS - 1));
            ST_PREAMB:  stage_end = (idx_q == IDX_W'(PREAMB_SYMS - 1));
            ST_PAYLOAD: stage_end = (idx_q == (IDX_W'(nbits_q) - IDX_W'(1)));
            ST_TAIL:    stage_end = 1'b1;
            default:    stage_end = 1'b0;
        endcase
        unique case (state_q)
            ST_PILOT:   follow_st = ST_PREAMB;
            ST_PREAMB:  follow_st = ST_PAYLOAD;
            ST_PAYLOAD: follow_st = ST_TAIL;
            ST_TAIL:    follow_st = ST_FINISH;
            default:    follow_st = ST_IDLE;
        endcase
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        nbits_d = nbits_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && (nbits_i != '0)) begin
                    state_d = pilot_en_i ? ST_PILOT : ST_PREAMB;
                    idx_d   = '0;
                    nbits_d = nbits_i;
                end
            end
            ST_PILOT, ST_PREAMB, ST_PAYLOAD, ST_TAIL: begin
                if (tick_i && second_pending) begin
                    if (stage_end) begin
                        idx_d   = '0;
                        state_d = follow_st;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                if (tick_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output-decode process
    always_comb begin
        do_load  = active && tick_i && !second_pending;
        do_shift = active && tick_i && second_pending;
        do_clear = (state_q == ST_FINISH) && tick_i;
        want_bit = do_shift &&
                   (((state_q == ST_PREAMB) && stage_end) ||
                    ((state_q == ST_PAYLOAD) && !stage_end));
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            nbits_q <= '0;
            bit_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            nbits_q <= nbits_d;
            done_q  <= do_clear;
            if (want_bit) begin
                bit_q <= bit_i;
            end
        end
    end

    fm0_pattern_src #(.IDX_W(IDX_W)) u_pattern (
        .st_i       (state_q),
        .idx_i      (idx_q),
        .data_bit_i (bit_q),
        .kind_o     (cur_kind)
    );

    fm0_sym_coder u_coder (
        .kind_i     (cur_kind),
        .prev_lvl_i (line_o),
        .pair_o     (cur_pair)
    );

    fm0_half_shifter u_shift (
        .clk              (clk),
        .rst_n            (rst_n),
        .load_i           (do_load),
        .pair_i           (cur_pair),
        .shift_i          (do_shift),
        .clear_i          (do_clear),
        .pair_o           (half_pair_o),
        .line_o           (line_o),
        .second_pending_o (second_pending)
    );

    assign bit_req_o = want_bit;
    assign done_o    = done_q;

endmodule

// File: rtl/fm0_line_encoder_chk.sv
`timescale 1ns/1ps
module fm0_line_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       bit_req_o,
    input logic [1:0] half_pair_o,
    input logic       line_o,
    input logic       done_o
);

    assert_line_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(line_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_line_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !line_o);

    assert_req_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |-> tick_i);

    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |=> !bit_req_o);

    assert_line_from_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> (half_pair_o != 2'b00));

endmodule

bind fm0_line_encoder fm0_line_encoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bit_req_o   (bit_req_o),
    .half_pair_o (half_pair_o),
    .line_o      (line_o),
    .done_o      (done_o)
);

// File: tb/fm0_line_encoder_tb_top.sv
`timescale 1ns/1ps
module fm0_line_encoder_tb_top;

    typedef struct {
        logic       line;
        logic [1:0] pair;
        logic       done;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, pilot_en_i, tick_i, bit_i;
    logic [6:0] nbits_i;
    logic       bit_req_o, line_o, done_o;
    logic [1:0] half_pair_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];
    logic exp_lvl;
    logic fb [0:127];
    int   req_total = 0;
    int   req_base  = 0;
    logic tick_seen = 1'b0;
    logic mon_on    = 1'b0;

    always #5 clk = ~clk;

    fm0_line_encoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pilot_en_i  (pilot_en_i),
        .nbits_i     (nbits_i),
        .tick_i      (tick_i),
        .bit_i       (bit_i),
        .bit_req_o   (bit_req_o),
        .half_pair_o (half_pair_o),
        .line_o      (line_o),
        .done_o      (done_o)
    );

    assign bit_i = fb[(req_total - req_base) & 127];

    always @(posedge clk) begin
        tick_seen <= tick_i;
        if (bit_req_o) req_total <= req_total + 1;
    end

    // Monitor: one expected half per tick, sampled on the following falling edge
    always @(negedge clk) begin
        if (mon_on && tick_seen && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (line_o !== e.line || half_pair_o !== e.pair || done_o !== e.done) begin
                n_fail++;
                $display("FAIL %s: line/pair/done got %b/%b/%b expected %b/%b/%b",
                         e.tag, line_o, half_pair_o, done_o, e.line, e.pair, e.done);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // kind: 0 = data 0, 1 = data 1, 2 = violation
    task automatic push_sym(input int kind, input string tag);
        logic a, b;
        exp_t e;
        a = (kind == 2) ? exp_lvl : ~exp_lvl;
        b = (kind == 0) ? ~a : a;
        exp_lvl = b;
        e.line = a; e.pair = {a, b}; e.done = 1'b0; e.tag = tag;
        exp_q.push_back(e);
        e.line = b;
        exp_q.push_back(e);
    endtask

    task automatic run_frame(input logic pil, input int n, input logic [7:0] seed,
                             input int period, input bit poke, input bit tick_at_start);
        exp_t e;
        int   total;
        exp_q.delete();
        exp_lvl = 1'b0;
        for (int i = 0; i < 128; i++) fb[i] = seed[i % 8] ^ ((i % 3) == 0);
        if (pil) for (int i = 0; i < 12; i++) push_sym(0, "R5 pilot");
        push_sym(1, "R4 preamble"); push_sym(0, "R4 preamble");
        push_sym(1, "R4 preamble"); push_sym(0, "R4 preamble");
        push_sym(2, "R4 violation"); push_sym(1, "R4 preamble");
        for (int i = 0; i < n; i++) push_sym(fb[i] ? 1 : 0, "R2 payload");
        push_sym(1, "R7 dummy");
        e.line = 1'b0; e.pair = 2'b00; e.done = 1'b1; e.tag = "R8 end";
        exp_q.push_back(e);
        total = exp_q.size();

        @(negedge clk);
        req_base   = req_total;
        start_i    = 1'b1;
        pilot_en_i = pil;
        nbits_i    = n[6:0];
        tick_i     = tick_at_start;
        @(negedge clk);
        start_i = 1'b0;
        tick_i  = 1'b0;
        @(posedge clk);
        mon_on = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 no half before first tick", int'(line_o), 0);
        for (int j = 0; j < total; j++) begin
            repeat (period - 1) @(negedge clk);
            tick_i = 1'b1;
            if (poke && j == total / 2) begin
                start_i    = 1'b1;
                nbits_i    = 7'd3;
                pilot_en_i = ~pil;
            end
            @(negedge clk);
            tick_i  = 1'b0;
            start_i = 1'b0;
        end
        repeat (2) @(negedge clk);
        mon_on = 1'b0;
        chk("R6 request count", req_total - req_base, n);
        chk("R8 all halves seen", exp_q.size(), 0);
        chk("R7 idle low after frame", int'(line_o), 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; pilot_en_i = 1'b0; nbits_i = '0; tick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line", int'(line_o), 0);
        chk("R1 pair", int'(half_pair_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 req", int'(bit_req_o), 0);

        run_frame(1'b0, 1,   8'hA5, 2, 1'b0, 1'b0);
        run_frame(1'b0, 8,   8'h3C, 3, 1'b0, 1'b1);  // R9 tick in start cycle
        run_frame(1'b1, 5,   8'h96, 1, 1'b1, 1'b0);  // R9 start while busy
        run_frame(1'b1, 127, 8'h5A, 1, 1'b0, 1'b0);
        run_frame(1'b0, 16,  8'hF0, 4, 1'b0, 1'b0);

        // R9: zero-length start must not begin a frame
        @(negedge clk);
        req_base = req_total;
        start_i = 1'b1; nbits_i = 7'd0; pilot_en_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9 zero count line idle", int'(line_o), 0);
            chk("R9 zero count no done", int'(done_o), 0);
        end
        tick_i = 1'b0;
        @(negedge clk);
        chk("R9 zero count no request", req_total - req_base, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule